// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

This block watches an eight-bit input bus that is already synchronized to its clock and raises one shared interrupt request from one of three sources. The first source is change of state: any edge, rising or falling, on a channel that software has selected. The second is a rising edge on input 0 and/or input 1. The third is an overflow pulse from an external watchdog counter. When a change-of-state event occurs, the block also stores the input word in a snapshot register, so software can read the pattern that caused the interrupt.

Software reaches the block through a 16-bit register port. Offset 0x06 writes the per-channel selection and reads back the snapshot. Offset 0x08 writes source enables and write-one-to-clear bits, and reads back the enables together with the pending flags. The three sources are meant to be used one at a time. If software enables more than one of them, the request output stays low and the pending flags keep running.

Top module: `cosirq_top`

## Requirements
- R1: A write to offset 0x06 stores an 8-bit channel selection from bits 7:0 (1 = selected). While the change-of-state source is enabled (control bit 8), any rising or falling edge on a selected input sets the change-of-state pending flag. An edge on an unselected input does not set it. An edge counts when the sampled input differs from its sample one clock earlier.
- R2: A change-of-state event captures the input word present in that cycle into the snapshot register. Bits 7:0 of a read at offset 0x06 return the snapshot, and bits 15:8 read 0.
- R3: Writing 1 to control bit 0 clears both the change-of-state pending flag and the snapshot (snapshot reads 0x00).
- R4: A read at offset 0x08 returns the source enables in bits 8 (change of state), 9 (input 0), 10 (input 1) and 15 (watchdog). It returns the pending flags in bits 0 (change of state), 1 (input 0), 2 (input 1) and 4 (watchdog). All other bits read 0.
- R5: With bit 9 or bit 10 enabled, only a 0-to-1 transition on input 0 or input 1 respectively sets that input's pending flag. A 1-to-0 transition does not.
- R6: With bit 15 enabled, a one-cycle high pulse on the watchdog overflow input sets the watchdog pending flag. With bit 15 clear, the pulse is ignored.
- R7: Writing 1 to control bit 0, 1, 2 or 7 clears only the change-of-state, input-0, input-1 or watchdog pending flag respectively. A write with these bits at 0 leaves every pending flag unchanged.
- R8: A pending flag stays set until software clears it. When an event arrives in the same cycle as the clear of its flag, the flag stays set, and for change of state the snapshot takes the new input word.
- R9: The request output is high when a pending flag of an enabled source is set and exactly one of the three modes is enabled. The three modes are change of state, rising edge (bit 9 or bit 10), and watchdog. With two or more modes enabled, or with none enabled, the output is low.
- R10: After reset, the selection, enables, pending flags and snapshot are all zero and the request output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe for the current cycle |
| regAddr | input | 4 | Register offset (0x06 or 0x08); selects both write and read |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for `regAddr`, combinational |
| dinBus | input | 8 | Synchronized digital inputs |
| wdtOverflow | input | 1 | Watchdog overflow pulse |
| irqOut | output | 1 | Shared interrupt request |

## Verification
The hardest case to reach is an event that lands in the same clock edge as the software clear of its own flag. The clear only exists for one cycle, as a write strobe, so the bench arranges it directly. It changes the input bus at the same falling edge where it raises the write of the clear bit. It then checks that the flag survives and that the snapshot holds the new word rather than zero. A related case is the mode-legality rule. Here the bench leaves a watchdog flag pending and then adds a second mode through a control write that clears nothing. This shows the request drops while the flag is still visible, and returns once the extra mode is removed.

// File: rtl/cosirq_pkg.sv
`timescale 1ns/1ps
package cosirq_pkg;
  localparam int CH_W    = 8;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 4;
  localparam int NUM_SRC = 4;

  localparam logic [ADDR_W-1:0] ADDR_MASK = 4'h6;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'h8;

  // Source index order used by every vector below
  localparam int SRC_COS = 0;
  localparam int SRC_CH0 = 1;
  localparam int SRC_CH1 = 2;
  localparam int SRC_WDT = 3;

  // Bit positions inside the control / status word, indexed by source
  localparam int CLR_POS [NUM_SRC] = '{0, 1, 2, 7};
  localparam int EN_POS  [NUM_SRC] = '{8, 9, 10, 15};
  localparam int ST_POS  [NUM_SRC] = '{0, 1, 2, 4};

  typedef struct packed {
    logic [NUM_SRC-1:0] clr;    // one-cycle clear strobes
    logic [NUM_SRC-1:0] en;     // registered source enables
    logic               legal;  // exactly one mode enabled
    logic [CH_W-1:0]    mask;   // change-of-state channel selection
  } ctlBus_t;
endpackage

// File: rtl/cosirq_ctrl.sv
`timescale 1ns/1ps
module cosirq_ctrl
  import cosirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [CH_W-1:0]   snap,
  output logic [DATA_W-1:0] rdData,
  output ctlBus_t           ctl
);
  logic [CH_W-1:0]    maskQ;
  logic [NUM_SRC-1:0] enQ;
  logic               ctlWrite;
  logic               ctrlUnused;

  assign ctlWrite   = wrEn && (addr == ADDR_CTRL);
  assign ctrlUnused = ^wrData[14:11];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      enQ   <= '0;
    end else if (wrEn) begin
      if (addr == ADDR_MASK) maskQ <= wrData[CH_W-1:0];
      if (addr == ADDR_CTRL) begin
        for (int i = 0; i < NUM_SRC; i++) enQ[i] <= wrData[EN_POS[i]];
      end
    end
  end

  always_comb begin
    ctl.clr = '0;
    for (int i = 0; i < NUM_SRC; i++) ctl.clr[i] = ctlWrite & wrData[CLR_POS[i]];
    ctl.en    = enQ;
    ctl.mask  = maskQ;
    ctl.legal = ($countones({enQ[SRC_COS], enQ[SRC_CH0] | enQ[SRC_CH1], enQ[SRC_WDT]}) == 1);
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_MASK) begin
      rdData[CH_W-1:0] = snap;
    end else if (addr == ADDR_CTRL) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        rdData[ST_POS[i]] = pend[i];
        rdData[EN_POS[i]] = enQ[i];
      end
    end
  end
endmodule

// File: rtl/cosirq_datapath.sv
`timescale 1ns/1ps
module cosirq_datapath
  import cosirq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CH_W-1:0]    din,
  input  logic               wdtPulse,
  input  ctlBus_t            ctl,
  output logic [NUM_SRC-1:0] pend,
  output logic [CH_W-1:0]    snap,
  output logic               irq
);
  logic [CH_W-1:0]    prevQ;
  logic [CH_W-1:0]    change;
  logic [CH_W-1:0]    rise;
  logic [NUM_SRC-1:0] evt;
  logic [NUM_SRC-1:0] pendQ;
  logic [CH_W-1:0]    snapQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= din;
  end

  always_comb begin
    change       = din ^ prevQ;
    rise         = din & ~prevQ;
    evt[SRC_COS] = ctl.en[SRC_COS] & (|(change & ctl.mask));
    evt[SRC_CH0] = ctl.en[SRC_CH0] & rise[0];
    evt[SRC_CH1] = ctl.en[SRC_CH1] & rise[1];
    evt[SRC_WDT] = ctl.en[SRC_WDT] & wdtPulse;
  end

  // one sticky flag per source; a new event outranks its clear
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pendQ[s] <= 1'b0;
      else       pendQ[s] <= evt[s] | (pendQ[s] & ~ctl.clr[s]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 snapQ <= '0;
    else if (evt[SRC_COS])     snapQ <= din;
    else if (ctl.clr[SRC_COS]) snapQ <= '0;
  end

  assign pend = pendQ;
  assign snap = snapQ;
  assign irq  = ctl.legal & (|(pendQ & ctl.en));
endmodule

// File: rtl/cosirq_top.sv
`timescale 1ns/1ps
module cosirq_top
  import cosirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CH_W-1:0]   dinBus,
  input  logic              wdtOverflow,
  output logic              irqOut
);
  ctlBus_t            ctlBus;
  logic [NUM_SRC-1:0] pendFlags;
  logic [CH_W-1:0]    snapWord;

  cosirq_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (regWrEn),
    .addr   (regAddr),
    .wrData (regWrData),
    .pend   (pendFlags),
    .snap   (snapWord),
    .rdData (regRdData),
    .ctl    (ctlBus)
  );

  cosirq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .din      (dinBus),
    .wdtPulse (wdtOverflow),
    .ctl      (ctlBus),
    .pend     (pendFlags),
    .snap     (snapWord),
    .irq      (irqOut)
  );
endmodule

// File: rtl/cosirq_chk.sv
`timescale 1ns/1ps
module cosirq_chk
  import cosirq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [CH_W-1:0]   dinBus,
  input logic              wdtOverflow,
  input logic              irqOut
);
  logic [CH_W-1:0] prevDin;
  logic [3:0]      shEn;
  logic            chkUnused;
  logic            ctrlWr;
  logic            quietIn;

  assign chkUnused = ^{regWrData[14:11], regWrData[6:3]};
  assign ctrlWr    = regWrEn && (regAddr == ADDR_CTRL);
  assign quietIn   = (dinBus == prevDin) && !wdtOverflow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevDin <= '0;
      shEn    <= '0;
    end else begin
      prevDin <= dinBus;
      if (ctrlWr) shEn <= {regWrData[15], regWrData[10], regWrData[9], regWrData[8]};
    end
  end

  AST_CLEAR_ALL_QUIETS: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && (regWrData[7:0] & 8'h87) == 8'h87 && quietIn) |=> !irqOut); // R7

  AST_SNAP_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWrData[0] && quietIn) |=> (regAddr != ADDR_MASK || regRdData[7:0] == 8'h00)); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !regWrEn) |=> irqOut); // R8

  AST_MULTI_MODE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({shEn[0], shEn[1] | shEn[2], shEn[3]}) != 1) |-> !irqOut); // R9

  AST_STATUS_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CTRL) |-> ((regRdData & 16'h78E8) == 16'h0000)); // R4
endmodule

bind cosirq_top cosirq_chk u_chk (.*);

// File: tb/sim_cosirq_top.sv
`timescale 1ns/1ps
module sim_cosirq_top;
  import cosirq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic [CH_W-1:0]   dinBus = '0;
  logic              wdtOverflow = 1'b0;
  logic              irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cosirq_top u0 (.*);

  // en order: {wdt, in1, in0, cos}; pend uses the same order
  typedef struct packed {
    logic [7:0] din0;
    logic [7:0] din1;
    logic       wdt;
    logic [3:0] en;
    logic [7:0] mask;
    logic [3:0] expPend;
    logic       expIrq;
    logic [7:0] expSnap;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h01, 1'b0, 4'b0001, 8'h01, 4'b0001, 1'b1, 8'h01}, // R1 R2 rising on selected
    '{8'h00, 8'h02, 1'b0, 4'b0001, 8'h01, 4'b0000, 1'b0, 8'h00}, // R1 unselected edge
    '{8'h05, 8'h04, 1'b0, 4'b0001, 8'hFF, 4'b0001, 1'b1, 8'h04}, // R1 R2 falling edge
    '{8'h00, 8'h01, 1'b0, 4'b0010, 8'h00, 4'b0010, 1'b1, 8'h00}, // R5 in0 rise
    '{8'h01, 8'h00, 1'b0, 4'b0010, 8'h00, 4'b0000, 1'b0, 8'h00}, // R5 in0 fall ignored
    '{8'h00, 8'h03, 1'b0, 4'b0110, 8'h00, 4'b0110, 1'b1, 8'h00}, // R5 both inputs
    '{8'h00, 8'h02, 1'b0, 4'b0100, 8'h00, 4'b0100, 1'b1, 8'h00}, // R5 in1 only
    '{8'h00, 8'h00, 1'b1, 4'b1000, 8'h00, 4'b1000, 1'b1, 8'h00}, // R6 overflow
    '{8'h00, 8'h00, 1'b1, 4'b0001, 8'h00, 4'b0000, 1'b0, 8'h00}, // R6 overflow ignored
    '{8'h00, 8'h01, 1'b0, 4'b0011, 8'hFF, 4'b0011, 1'b0, 8'h01}, // R9 forbidden pair
    '{8'h10, 8'h10, 1'b0, 4'b0001, 8'hFF, 4'b0000, 1'b0, 8'h00}, // R1 no change
    '{8'h00, 8'hFF, 1'b0, 4'b0000, 8'hFF, 4'b0000, 1'b0, 8'h00}  // R9 nothing enabled
  };

  function automatic logic [15:0] enWord(input logic [3:0] en);
    return {en[3], 4'b0000, en[2:0], 8'h00};
  endfunction

  function automatic logic [15:0] statWord(input logic [3:0] en, input logic [3:0] pend);
    return {en[3], 4'b0000, en[2:0], 3'b000, pend[3], 1'b0, pend[2:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%04h expected=0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    regAddr = a;
    #0.5;
    d = regRdData;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R10 reset state, still in reset and just after release
    rd(ADDR_MASK, r); check("R10 snapshot", r, 16'h0000);
    rd(ADDR_CTRL, r); check("R10 status", r, 16'h0000);
    check("R10 irq", {15'd0, irqOut}, 16'h0000);
    rstN = 1'b1;
    @(negedge clk);
    rd(ADDR_CTRL, r); check("R10 status after release", r, 16'h0000);

    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      dinBus = v.din0;
      @(negedge clk);
      wr(ADDR_MASK, {8'h00, v.mask});
      wr(ADDR_CTRL, enWord(v.en) | 16'h0087);
      dinBus = v.din1; wdtOverflow = v.wdt;
      @(negedge clk);
      wdtOverflow = 1'b0;
      rd(ADDR_CTRL, r); check($sformatf("R1 R4 R5 R6 status vec %0d", k), r, statWord(v.en, v.expPend));
      rd(ADDR_MASK, r); check($sformatf("R2 snapshot vec %0d", k), r, {8'h00, v.expSnap});
      check($sformatf("R9 irq vec %0d", k), {15'd0, irqOut}, {15'd0, v.expIrq});
    end

    // R8 hold, R7 zero write, R3 clear
    dinBus = 8'h00; @(negedge clk);
    wr(ADDR_MASK, 16'h00FF);
    wr(ADDR_CTRL, 16'h0187);
    dinBus = 8'h01; @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 irq held", {15'd0, irqOut}, 16'h0001);
    wr(ADDR_CTRL, 16'h0100);
    rd(ADDR_CTRL, r); check("R7 zero clear no effect", r, 16'h0101);
    wr(ADDR_CTRL, 16'h0101);
    rd(ADDR_CTRL, r); check("R3 pending cleared", r, 16'h0100);
    rd(ADDR_MASK, r); check("R3 snapshot cleared", r, 16'h0000);
    check("R3 irq low", {15'd0, irqOut}, 16'h0000);

    // R8 event in the same cycle as its clear
    dinBus = 8'h03; @(negedge clk);
    dinBus = 8'h07;
    wr(ADDR_CTRL, 16'h0101);
    rd(ADDR_CTRL, r); check("R8 event beats clear", r, 16'h0101);
    rd(ADDR_MASK, r); check("R8 snapshot new word", r, 16'h0007);

    // R7 selective clears
    dinBus = 8'h00; @(negedge clk);
    wr(ADDR_CTRL, 16'h0687);
    dinBus = 8'h03; @(negedge clk);
    rd(ADDR_CTRL, r); check("R5 both pending", r, 16'h0606);
    wr(ADDR_CTRL, 16'h0602);
    rd(ADDR_CTRL, r); check("R7 clear in0 only", r, 16'h0604);
    check("R7 irq stays", {15'd0, irqOut}, 16'h0001);
    wr(ADDR_CTRL, 16'h0604);
    rd(ADDR_CTRL, r); check("R7 clear in1", r, 16'h0600);
    check("R7 irq low", {15'd0, irqOut}, 16'h0000);

    // R9 legality with watchdog pending
    wr(ADDR_CTRL, 16'h8087);
    wdtOverflow = 1'b1; @(negedge clk); wdtOverflow = 1'b0;
    rd(ADDR_CTRL, r); check("R6 overflow pending", r, 16'h8010);
    check("R9 single mode irq", {15'd0, irqOut}, 16'h0001);
    wr(ADDR_CTRL, 16'h8100);
    rd(ADDR_CTRL, r); check("R9 flag kept", r, 16'h8110);
    check("R9 two modes silent", {15'd0, irqOut}, 16'h0000);
    wr(ADDR_CTRL, 16'h8000);
    check("R9 irq returns", {15'd0, irqOut}, 16'h0001);
    wr(ADDR_CTRL, 16'h8080);
    rd(ADDR_CTRL, r); check("R7 clear watchdog", r, 16'h8000);
    check("R7 watchdog irq low", {15'd0, irqOut}, 16'h0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule